// File: doc/BRIEF.md
# Gated Interface Clock Generator

This block produces the bit clock and the 8 kHz frame strobe for a serial interface that carries two bearer channels and one signalling channel. It works in master mode and divides a fast reference clock. With the default parameters and a 40.96 MHz reference, speed select 0 gives a 2.56 MHz bit clock with 320 bits per frame. Speed select 1 gives a 2.048 MHz bit clock with 256 bits per frame. In both cases a frame lasts 125 us.

A gating control selects one of two run policies. In the first, the outputs run whenever the block is master. In the second, they run only while the line transceiver is up: a superframe-sync flag starts them and a teardown flag stops them. The master/slave pin passes through an optional polarity inversion before the block decides its mode. Starts, stops and speed changes wait for a frame boundary, so the interface never sees a truncated bit or a partial frame. The one exception is leaving master mode, which silences the outputs at once.

Top module: `icg_top`

## Requirements
- R1: While `rst_n` is low and after its release, `dclk` and `fsync` are 0 and the link flag is clear.
- R2: `master_eff` equals `ms_pin` XOR `ms_invert`: a high pin with `ms_invert`=0 selects master, and `ms_invert`=1 swaps the sense.
- R3: In the cycle after `master_eff` is seen low at a clock edge, `dclk` and `fsync` are 0, even in the middle of a frame.
- R4: With `gate_on_link`=0, an idle master begins a frame at the first reference edge that sees `master_eff` high, and frames then follow back to back.
- R5: Each bit drives `dclk` high for HALF reference cycles and then low for HALF cycles. With `speed_sel`=0, HALF is HALF_FAST and a frame has BITS_FAST bits. With `speed_sel`=1, HALF is HALF_SLOW and a frame has BITS_SLOW bits.
- R6: `fsync` is high for exactly the first bit period (2*HALF cycles) of every frame and low at all other times.
- R7: With `gate_on_link`=1, the link flag is set at the edge that samples `sf_sync`=1. An idle master starts a frame at the following edge. While the flag is clear, no frame starts.
- R8: `teardown` clears the link flag. A running frame still completes, and with `gate_on_link`=1 the outputs then stop at the frame boundary with `dclk` low.
- R9: If `sf_sync` and `teardown` are both high in the same cycle, `teardown` wins and the link flag is left clear.
- R10: `speed_sel` is sampled only when a frame starts. A change in the middle of a frame takes effect at the next frame.
- R11: While `master_eff` stays high, a running output stream stops only at the last reference cycle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_sel | input | 1 | 0: fast rate, 1: slow rate |
| gate_on_link | input | 1 | 0: run continuously, 1: run only while the link is up |
| sf_sync | input | 1 | Superframe sync acquired |
| teardown | input | 1 | Line transceiver in the teardown state |
| ms_pin | input | 1 | Master/slave selection pin |
| ms_invert | input | 1 | Inverts the polarity of `ms_pin` |
| dclk | output | 1 | Interface bit clock |
| fsync | output | 1 | Frame strobe, high during bit 0 |
| master_eff | output | 1 | Effective master indication |

## Verification
The frame-boundary decision can coincide with a change to its own inputs. In the last reference cycle of a frame, the restart-or-stop choice and the new speed sample are taken together. That same cycle can also see a teardown clearing the link flag or a speed toggle. The bench provokes this by toggling `speed_sel` mid-frame and pulsing `teardown` mid-frame. It also applies random toggles that land on frame edges, and it compares every cycle against a frame-position model that applies the stop and the new speed only at the wrap. A second same-cycle case, with superframe sync and teardown asserted together, is driven directly and judged by the outputs staying silent.

// File: rtl/icg_pkg.sv
package icg_pkg;
  // Which half of a bit period the divider is in
  typedef enum logic {PH_HIGH = 1'b0, PH_LOW = 1'b1} half_t;
endpackage

// File: rtl/icg_link_gate.sv
module icg_link_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic gate_on_link,
  input  logic sf_sync,
  input  logic teardown,
  output logic link_up,
  output logic run_req
);
  // teardown has priority over superframe sync
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        link_up <= 1'b0;
    else if (teardown) link_up <= 1'b0;
    else if (sf_sync)  link_up <= 1'b1;
  end

  assign run_req = master & (~gate_on_link | link_up);
endmodule

// File: rtl/icg_half_timer.sv
module icg_half_timer #(
  parameter int HW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [HW-1:0]   hlast,
  output logic            half_end,
  output icg_pkg::half_t  phase
);
  import icg_pkg::*;

  logic [HW-1:0] cnt;

  assign half_end = (cnt == hlast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= PH_HIGH;
    end else if (clr) begin
      cnt   <= '0;
      phase <= PH_HIGH;
    end else if (half_end) begin
      cnt   <= '0;
      phase <= (phase == PH_HIGH) ? PH_LOW : PH_HIGH;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/icg_frame_seq.sv
module icg_frame_seq #(
  parameter int BITS_FAST = 320,
  parameter int BITS_SLOW = 256,
  parameter int BW        = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           master,
  input  logic           run_req,
  input  logic           speed_sel,
  input  logic           half_end,
  input  icg_pkg::half_t phase,
  output logic           running,
  output logic           spd,
  output logic [BW-1:0]  bit_idx,
  output logic           bit_end,
  output logic           frame_end,
  output logic           timer_clr
);
  import icg_pkg::*;

  function automatic logic [BW-1:0] bits_last(input logic slow);
    return slow ? BW'(BITS_SLOW - 1) : BW'(BITS_FAST - 1);
  endfunction

  assign bit_end   = running & half_end & (phase == PH_LOW);
  assign frame_end = bit_end & (bit_idx == bits_last(spd));
  assign timer_clr = ~running | frame_end | ~master;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      spd     <= 1'b0;
      bit_idx <= '0;
    end else if (!master) begin
      running <= 1'b0;
      bit_idx <= '0;
    end else if (!running) begin
      bit_idx <= '0;
      if (run_req) begin
        running <= 1'b1;
        spd     <= speed_sel;
      end
    end else if (frame_end) begin
      bit_idx <= '0;
      running <= run_req;
      if (run_req) spd <= speed_sel;
    end else if (bit_end) begin
      bit_idx <= bit_idx + 1'b1;
    end
  end
endmodule

// File: rtl/icg_top.sv
module icg_top #(
  parameter int HALF_FAST = 8,
  parameter int HALF_SLOW = 10,
  parameter int BITS_FAST = 320,
  parameter int BITS_SLOW = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic speed_sel,
  input  logic gate_on_link,
  input  logic sf_sync,
  input  logic teardown,
  input  logic ms_pin,
  input  logic ms_invert,
  output logic dclk,
  output logic fsync,
  output logic master_eff
);
  import icg_pkg::*;

  localparam int HALF_MAX = (HALF_FAST > HALF_SLOW) ? HALF_FAST : HALF_SLOW;
  localparam int BITS_MAX = (BITS_FAST > BITS_SLOW) ? BITS_FAST : BITS_SLOW;
  localparam int HW = $clog2(HALF_MAX + 1);
  localparam int BW = $clog2(BITS_MAX + 1);

  function automatic logic [HW-1:0] half_last(input logic slow);
    return slow ? HW'(HALF_SLOW - 1) : HW'(HALF_FAST - 1);
  endfunction

  // Named internal events, also observed by the checker
  logic          link_up, run_req;
  logic          running_w, spd_w, bit_end_w, frame_end_w, timer_clr_w;
  logic          half_end_w;
  half_t         phase_w;
  logic [BW-1:0] bit_idx_w;

  assign master_eff = ms_pin ^ ms_invert;

  icg_link_gate u_gate (
    .clk(clk), .rst_n(rst_n), .master(master_eff), .gate_on_link(gate_on_link),
    .sf_sync(sf_sync), .teardown(teardown), .link_up(link_up), .run_req(run_req)
  );

  icg_half_timer #(.HW(HW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(timer_clr_w), .hlast(half_last(spd_w)),
    .half_end(half_end_w), .phase(phase_w)
  );

  icg_frame_seq #(.BITS_FAST(BITS_FAST), .BITS_SLOW(BITS_SLOW), .BW(BW)) u_seq (
    .clk(clk), .rst_n(rst_n), .master(master_eff), .run_req(run_req),
    .speed_sel(speed_sel), .half_end(half_end_w), .phase(phase_w),
    .running(running_w), .spd(spd_w), .bit_idx(bit_idx_w), .bit_end(bit_end_w),
    .frame_end(frame_end_w), .timer_clr(timer_clr_w)
  );

  assign dclk  = running_w & (phase_w == PH_HIGH);
  assign fsync = running_w & (bit_idx_w == '0);
endmodule

// File: rtl/icg_checker.sv
module icg_checker (
  input logic clk,
  input logic rst_n,
  input logic master_eff,
  input logic gate_on_link,
  input logic teardown,
  input logic dclk,
  input logic fsync,
  input logic run_active,
  input logic frame_end,
  input logic link_up,
  input logic spd
);
  assert_slave_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !master_eff |=> (!dclk && !fsync));

  assert_strobe_with_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync) |-> dclk);

  assert_gate_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on_link && !link_up && !run_active) |=> !run_active);

  assert_end_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> !dclk);

  assert_teardown_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    teardown |=> !link_up);

  assert_speed_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_active && master_eff && !frame_end) |=> $stable(spd));

  assert_no_mid_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run_active && master_eff && !frame_end) |=> run_active);
endmodule

bind icg_top icg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .master_eff(master_eff), .gate_on_link(gate_on_link),
  .teardown(teardown), .dclk(dclk), .fsync(fsync), .run_active(running_w),
  .frame_end(frame_end_w), .link_up(link_up), .spd(spd_w)
);

// File: tb/tb_icg_top.sv
`timescale 1ns/1ps
module tb_icg_top;
  localparam int HF = 2, HS = 3, BF = 6, BS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic speed_sel = 1'b0, gate_on_link = 1'b0, sf_sync = 1'b0, teardown = 1'b0;
  logic ms_pin = 1'b0, ms_invert = 1'b0;
  logic dclk, fsync, master_eff;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  icg_top #(.HALF_FAST(HF), .HALF_SLOW(HS), .BITS_FAST(BF), .BITS_SLOW(BS)) dut (
    .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel), .gate_on_link(gate_on_link),
    .sf_sync(sf_sync), .teardown(teardown), .ms_pin(ms_pin), .ms_invert(ms_invert),
    .dclk(dclk), .fsync(fsync), .master_eff(master_eff)
  );

  function automatic int hh(input logic s); return s ? HS : HF; endfunction
  function automatic int flen(input logic s); return 2 * hh(s) * (s ? BS : BF); endfunction

  // Frame-position reference model
  logic m_link, m_run, m_spd;
  int   m_pos;
  wire  m_master = ms_pin ^ ms_invert;
  wire  m_req = m_master && (!gate_on_link || m_link);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_link <= 1'b0; m_run <= 1'b0; m_spd <= 1'b0; m_pos <= 0;
    end else begin
      m_link <= teardown ? 1'b0 : (sf_sync ? 1'b1 : m_link);
      if (!m_master) begin
        m_run <= 1'b0; m_pos <= 0;
      end else if (!m_run) begin
        m_pos <= 0;
        if (m_req) begin m_run <= 1'b1; m_spd <= speed_sel; end
      end else if (m_pos == flen(m_spd) - 1) begin
        m_pos <= 0; m_run <= m_req;
        if (m_req) m_spd <= speed_sel;
      end else begin
        m_pos <= m_pos + 1;
      end
    end
  end

  function automatic logic exp_dclk();
    return m_run && (((m_pos / hh(m_spd)) % 2) == 0);
  endfunction
  function automatic logic exp_fs();
    return m_run && (m_pos < 2 * hh(m_spd));
  endfunction

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    // R2 truth table while held in reset
    for (int i = 0; i < 4; i++) begin
      ms_pin = i[0]; ms_invert = i[1];
      #1;
      chk("R2 master polarity", master_eff, i[0] ^ i[1]);
    end
    ms_pin = 1'b1; ms_invert = 1'b0; gate_on_link = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset dclk", dclk, 1'b0);
    chk("R1 reset fsync", fsync, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 R7 idle with link clear", dclk, 1'b0);

    // R9: simultaneous superframe sync and teardown
    sf_sync = 1'b1; teardown = 1'b1;
    @(negedge clk); sf_sync = 1'b0; teardown = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 teardown wins, no start", dclk, 1'b0);

    // R7: start two edges after sf_sync is sampled
    sf_sync = 1'b1;
    @(negedge clk); sf_sync = 1'b0;
    chk("R7 flag set, not yet running", dclk, 1'b0);
    @(negedge clk);
    chk("R7 start dclk", dclk, 1'b1);
    chk("R6 start fsync", fsync, 1'b1);

    // R8: teardown mid-frame, frame completes then stops (fast: 24 cycles)
    for (int obs = 1; obs <= 24; obs++) begin
      if (obs == 5) teardown = 1'b1;
      @(negedge clk);
      teardown = 1'b0;
      if (obs == 4) chk("R6 fsync low after bit 0", fsync, 1'b0);
      if (obs == 20) chk("R8 frame continues after teardown", dclk, 1'b1);
    end
    chk("R8 stopped at boundary dclk", dclk, 1'b0);
    chk("R8 stopped at boundary fsync", fsync, 1'b0);

    // R4: free-run starts at the next edge
    gate_on_link = 1'b0;
    @(negedge clk);
    chk("R4 free-run start dclk", dclk, 1'b1);
    chk("R4 free-run start fsync", fsync, 1'b1);

    // R10: speed change mid-frame
    for (int obs = 1; obs <= 30; obs++) begin
      if (obs == 4) speed_sel = 1'b1;
      @(negedge clk);
      if (obs == 6)  chk("R10 old speed kept mid-frame", dclk, 1'b0);
      if (obs == 24) chk("R4 R6 back-to-back frame strobe", fsync, 1'b1);
      if (obs == 30) chk("R5 R10 new speed next frame", dclk, 1'b1);
    end

    // R3: leaving master mid-frame silences outputs next cycle
    ms_invert = 1'b1;
    @(negedge clk);
    chk("R3 slave dclk", dclk, 1'b0);
    chk("R3 slave fsync", fsync, 1'b0);
    ms_invert = 1'b0;

    // Random stimulus against the model
    void'($urandom(32'd2024));
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      chk("R3 R4 R5 R6 R7 R8 R10 R11 model dclk", dclk, exp_dclk());
      chk("R5 R6 R11 model fsync", fsync, exp_fs());
      chk("R2 model master", master_eff, m_master);
      sf_sync = 1'b0; teardown = 1'b0;
      if ($urandom_range(39, 0) == 0) speed_sel = ~speed_sel;
      if ($urandom_range(59, 0) == 0) sf_sync = 1'b1;
      if ($urandom_range(79, 0) == 0) teardown = 1'b1;
      if ($urandom_range(299, 0) == 0) gate_on_link = ~gate_on_link;
      if ($urandom_range(399, 0) == 0) ms_pin = ~ms_pin;
      if ($urandom_range(599, 0) == 0) ms_invert = ~ms_invert;
    end
    summary();
  end
endmodule